// File: doc/BRIEF.md
# Signed/Unsigned Magnitude Comparator

This block orders two equal-width binary operands, A and B, and reports whether A is greater than, less than or equal to B. A single mode input chooses between plain unsigned ordering and two's-complement signed ordering. It is purely combinational, with no clock, no state and no handshake, and is meant to sit inside wider datapath logic such as branch resolution, clamping or sorting networks.

Internally the block does not compare bit by bit. It subtracts, forming B − A as B plus the bitwise inverse of A with a forced carry-in of one, on a logarithmic-depth parallel-prefix carry tree. The relation is then read off the flags of that subtraction. The carry-out decides unsigned order. For signed order, the sign of the difference is corrected by XOR with the signed-overflow flag. An all-zero detector on the difference decides equality in both modes.

Top module: `mag_compare`

## Requirements
- R1: With `signed_mode_i` = 0, `agtb_o` is 1 exactly when A > B taken as unsigned numbers.
- R2: With `signed_mode_i` = 0, `altb_o` is 1 exactly when A < B taken as unsigned numbers.
- R3: `eq_o` is 1 exactly when every bit of A equals the corresponding bit of B, in either mode.
- R4: With `signed_mode_i` = 1, the operands are two's-complement numbers whose most significant bit is the sign. `agtb_o` is 1 exactly when A > B and `altb_o` is 1 exactly when A < B.
- R5: For every input combination, exactly one of `agtb_o`, `altb_o` and `eq_o` is 1.
- R6: In signed mode, A = most negative value (sign bit 1, all other bits 0) against B = most positive value (sign bit 0, all other bits 1) gives `altb_o` = 1. The swapped pair gives `agtb_o` = 1.
- R7: The pair A = all ones, B = all zeros gives `altb_o` = 1 in signed mode (−1 < 0) and `agtb_o` = 1 in unsigned mode.
- R8: In unsigned mode, A = 0 against B = all ones gives `altb_o` = 1. The swapped pair gives `agtb_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| signed_mode_i | input | 1 | 1 = two's-complement ordering, 0 = unsigned ordering |
| agtb_o | output | 1 | A is greater than B |
| altb_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |

## Verification
The bench builds two copies of the block. One is at the default WIDTH of 16 and one at WIDTH of 8. The 8-bit copy is swept over every operand pair in both modes, about 131k vectors. That reaches every carry chain length through the three-stage prefix tree and every sign combination of the overflow correction. The 16-bit copy uses a four-stage tree. It gets the named boundary pairs, operands that differ only in the top or bottom bit, equal operands and random vectors. This exercises the longest carry spans that cross the stage distance of 8.

// File: rtl/mag_compare_pkg.sv
package mag_compare_pkg;

    typedef enum logic {
        ORDER_UNSIGNED = 1'b0,
        ORDER_SIGNED   = 1'b1
    } order_mode_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
        logic cout;
    } sub_flags_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } relation_t;

endpackage

// File: rtl/mag_compare_pg.sv
module mag_compare_pg #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);
    // Bit generate and propagate, with the forced carry-in folded into bit 0.
    logic [WIDTH-1:0] gen_d;
    logic [WIDTH-1:0] prop_d;

    always_comb begin
        prop_d = x_i ^ y_i;
        gen_d  = x_i & y_i;
        gen_d[0] = gen_d[0] | prop_d[0];
    end

    assign gen_o  = gen_d;
    assign prop_o = prop_d;
endmodule

// File: rtl/mag_compare_stage.sv
module mag_compare_stage #(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] p_i,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);
    // One Kogge-Stone level: every position combines with the one DIST below.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= DIST) begin : g_black
            assign g_o[i] = g_i[i] | (p_i[i] & g_i[i-DIST]);
            assign p_o[i] = p_i[i] & p_i[i-DIST];
        end else begin : g_pass
            assign g_o[i] = g_i[i];
            assign p_o[i] = p_i[i];
        end
    end
endmodule

// File: rtl/mag_compare_decide.sv
module mag_compare_decide
    import mag_compare_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] diff_i,
    input  logic             cout_i,
    input  logic             a_msb_i,
    input  logic             b_msb_i,
    input  order_mode_e      mode_i,
    output relation_t        rel_o
);
    sub_flags_t flags_d;
    relation_t  rel_d;
    logic       a_bigger;

    always_comb begin
        flags_d.zero = ~|diff_i;
        flags_d.neg  = diff_i[WIDTH-1];
        flags_d.cout = cout_i;
        // B - A overflows when signs differ and the result sign leaves B's sign.
        flags_d.ovf  = (a_msb_i ^ b_msb_i) & (flags_d.neg ^ b_msb_i);

        if (mode_i == ORDER_SIGNED) a_bigger = flags_d.neg ^ flags_d.ovf;
        else                        a_bigger = ~flags_d.cout;

        rel_d.eq = flags_d.zero;
        rel_d.gt = a_bigger & ~flags_d.zero;
        rel_d.lt = ~rel_d.gt & ~rel_d.eq;
    end

    assign rel_o = rel_d;
endmodule

// File: rtl/mag_compare.sv
module mag_compare
    import mag_compare_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             signed_mode_i,
    output logic             agtb_o,
    output logic             altb_o,
    output logic             eq_o
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] a_inv;
    logic [WIDTH-1:0] bit_g;
    logic [WIDTH-1:0] bit_p;
    logic [WIDTH-1:0] carry_in_d;
    logic [WIDTH-1:0] diff_d;
    logic [WIDTH-1:0] grp_g;
    logic [WIDTH-1:0] grp_p;
    relation_t        rel;

    assign a_inv = ~a_i;

    mag_compare_pg #(.WIDTH(WIDTH)) u_pg (
        .x_i    (b_i),
        .y_i    (a_inv),
        .gen_o  (bit_g),
        .prop_o (bit_p)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        logic [WIDTH-1:0] g_q;
        logic [WIDTH-1:0] p_q;
        if (l == 0) begin : g_first
            mag_compare_stage #(.WIDTH(WIDTH), .DIST(1)) u_stage (
                .g_i (bit_g), .p_i (bit_p), .g_o (g_q), .p_o (p_q)
            );
        end else begin : g_next
            mag_compare_stage #(.WIDTH(WIDTH), .DIST(1 << l)) u_stage (
                .g_i (g_lvl[l-1].g_q), .p_i (g_lvl[l-1].p_q), .g_o (g_q), .p_o (p_q)
            );
        end
    end

    assign grp_g = g_lvl[LEVELS-1].g_q;
    assign grp_p = g_lvl[LEVELS-1].p_q;

    // Carry into bit i is the group generate of bits i-1..0 (carry-in of 1 folded in).
    always_comb begin
        carry_in_d = {grp_g[WIDTH-2:0], 1'b1};
        diff_d     = bit_p ^ carry_in_d;
    end

    mag_compare_decide #(.WIDTH(WIDTH)) u_decide (
        .diff_i  (diff_d),
        .cout_i  (grp_g[WIDTH-1]),
        .a_msb_i (a_i[WIDTH-1]),
        .b_msb_i (b_i[WIDTH-1]),
        .mode_i  (order_mode_e'(signed_mode_i)),
        .rel_o   (rel)
    );

    assign agtb_o = rel.gt;
    assign altb_o = rel.lt;
    assign eq_o   = rel.eq;

    logic unused_p;
    assign unused_p = ^grp_p;
endmodule

// File: rtl/mag_compare_chk.sv
module mag_compare_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             signed_mode_i,
    input logic             agtb_o,
    input logic             altb_o,
    input logic             eq_o
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MOST_POS = {1'b0, {(WIDTH-1){1'b1}}};

    always_comb begin
        AST_ONE_HOT: assert ($countones({agtb_o, altb_o, eq_o}) == 1); // R5
        AST_EQ_BITS: assert (eq_o == (a_i == b_i)); // R3
        if (!signed_mode_i) begin
            AST_UNS_GT: assert (agtb_o == (a_i > b_i)); // R1
            AST_UNS_LT: assert (altb_o == (a_i < b_i)); // R2
        end else begin
            AST_SGN_GT: assert (agtb_o == ($signed(a_i) > $signed(b_i))); // R4
            AST_SGN_LT: assert (altb_o == ($signed(a_i) < $signed(b_i))); // R4
        end
        if (signed_mode_i && a_i == MOST_NEG && b_i == MOST_POS) begin
            AST_SGN_EXTREME: assert (altb_o); // R6
        end
    end
endmodule

bind mag_compare mag_compare_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i           (a_i),
    .b_i           (b_i),
    .signed_mode_i (signed_mode_i),
    .agtb_o        (agtb_o),
    .altb_o        (altb_o),
    .eq_o          (eq_o)
);

// File: tb/mag_compare_test.sv
`timescale 1ns/1ps
module mag_compare_test;
    localparam int W  = 16;
    localparam int W8 = 8;
    localparam int WATCHDOG_CYCLES = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0]  a, b;
    logic          smode;
    logic          gt, lt, eq;
    logic [W8-1:0] a8, b8;
    logic          smode8;
    logic          gt8, lt8, eq8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mag_compare #(.WIDTH(W)) uut (
        .a_i(a), .b_i(b), .signed_mode_i(smode),
        .agtb_o(gt), .altb_o(lt), .eq_o(eq)
    );

    mag_compare #(.WIDTH(W8)) uut8 (
        .a_i(a8), .b_i(b8), .signed_mode_i(smode8),
        .agtb_o(gt8), .altb_o(lt8), .eq_o(eq8)
    );

    // Drive, let it settle, compare all three outputs with relational operators.
    task automatic apply16(input logic [W-1:0] av, input logic [W-1:0] bv,
                           input logic sm, input string req);
        logic eg, el, ee;
        a = av; b = bv; smode = sm;
        #2;
        ee = (av == bv);
        eg = sm ? ($signed(av) > $signed(bv)) : (av > bv);
        el = sm ? ($signed(av) < $signed(bv)) : (av < bv);
        checks++;
        if ({gt, lt, eq} !== {eg, el, ee}) begin
            fails++;
            $display("FAIL %s a=%h b=%h signed=%0b got gt/lt/eq=%b%b%b expected %b%b%b",
                     req, av, bv, sm, gt, lt, eq, eg, el, ee);
        end
    endtask

    task automatic expect16(input logic [W-1:0] av, input logic [W-1:0] bv, input logic sm,
                            input logic [2:0] want, input string req);
        a = av; b = bv; smode = sm;
        #2;
        checks++;
        if ({gt, lt, eq} !== want) begin
            fails++;
            $display("FAIL %s a=%h b=%h signed=%0b got gt/lt/eq=%b%b%b expected %b",
                     req, av, bv, sm, gt, lt, eq, want);
        end
    endtask

    task automatic test_reset_state();
        // No state: first settled vector after reset release must already be valid (R3).
        expect16('0, '0, 1'b0, 3'b001, "R3 initial");
        expect16('0, '0, 1'b1, 3'b001, "R3 initial signed");
    endtask

    task automatic test_signed_extremes();
        logic [W-1:0] mneg, mpos;
        mneg = {1'b1, {(W-1){1'b0}}};
        mpos = {1'b0, {(W-1){1'b1}}};
        expect16(mneg, mpos, 1'b1, 3'b010, "R6 min<max");
        expect16(mpos, mneg, 1'b1, 3'b100, "R6 max>min");
        expect16(mneg, mpos, 1'b0, 3'b100, "R1 unsigned view of min/max");
    endtask

    task automatic test_minus_one_zero();
        expect16('1, '0, 1'b1, 3'b010, "R7 -1<0 signed");
        expect16('1, '0, 1'b0, 3'b100, "R7 all-ones>0 unsigned");
        expect16('0, '1, 1'b1, 3'b100, "R7 0>-1 signed");
    endtask

    task automatic test_unsigned_extremes();
        expect16('0, '1, 1'b0, 3'b010, "R8 0<max unsigned");
        expect16('1, '0, 1'b0, 3'b100, "R8 max>0 unsigned");
    endtask

    task automatic test_single_bit_diffs();
        for (int i = 0; i < W; i++) begin
            logic [W-1:0] base;
            base = W'($urandom);
            apply16(base, base ^ (W'(1) << i), 1'b0, "R1/R2 one-bit diff");
            apply16(base, base ^ (W'(1) << i), 1'b1, "R4 one-bit diff");
            apply16(base, base, i[0], "R3 equal");
        end
    endtask

    task automatic test_random16();
        for (int n = 0; n < 4000; n++) begin
            logic [W-1:0] av, bv;
            av = W'($urandom);
            bv = (n % 7 == 0) ? av : W'($urandom);
            apply16(av, bv, n[0], n[0] ? "R4 random" : "R1/R2 random");
        end
    endtask

    task automatic test_exhaustive8();
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    logic eg, el, ee;
                    a8 = W8'(x); b8 = W8'(y); smode8 = m[0];
                    #1;
                    ee = (x == y);
                    eg = m[0] ? ($signed(a8) > $signed(b8)) : (x > y);
                    el = m[0] ? ($signed(a8) < $signed(b8)) : (x < y);
                    checks++;
                    if ({gt8, lt8, eq8} !== {eg, el, ee} || $countones({gt8, lt8, eq8}) != 1) begin
                        fails++;
                        $display("FAIL R5/R4/R1 8-bit a=%h b=%h signed=%0d got %b%b%b expected %b%b%b",
                                 a8, b8, m, gt8, lt8, eq8, eg, el, ee);
                    end
                end
            end
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; smode = 1'b0;
        a8 = '0; b8 = '0; smode8 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        test_signed_extremes();
        test_minus_one_zero();
        test_unsigned_extremes();
        test_single_bit_diffs();
        test_random16();
        test_exhaustive8();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule